// File: doc/BRIEF.md
# Polar BP Butterfly Processing Element

This block computes message updates for belief-propagation decoding of polar codes. Each lane evaluates one 2-by-2 butterfly of the factor graph. A lane takes four signed fixed-point log-likelihood ratios:

- the two right-travelling messages of a layer: the upper node `r_hi` and the node half a block further down, `r_lo`;
- the two left-travelling messages of the next layer: the odd node `l_odd` and the even node `l_even`.

From these it returns four updated messages: two travelling left on the lower layer and two travelling right on the upper layer. The combining function is the min-sum box `g(x,y) = sign(x)·sign(y)·min(|x|,|y|)`, mixed with saturating additions.

`LANES` butterflies run side by side and share one valid strobe. A group of inputs accepted with `in_valid` comes out after exactly `LAT` clock cycles, marked by `out_valid`. The surrounding decoder owns the message memories, the schedule and the hard decisions. It streams one group per cycle into this unit and writes the results back.

Top module: `polar_bp_pe_array`

## Requirements
- R1: `l_hi_o` = g(`l_odd_i`, S), where S = sat(`l_even_i` + `r_lo_i`).
- R2: `l_lo_o` = sat(g(`r_hi_i`, `l_odd_i`) + `l_even_i`).
- R3: `r_odd_o` = g(`r_hi_i`, S), with S as in R1.
- R4: `r_even_o` = sat(g(`r_hi_i`, `l_odd_i`) + `r_lo_i`).
- R5: g returns the smaller of the two input magnitudes. Its sign is negative exactly when the two inputs have opposite signs, and it is 0 when either input is 0.
- R6: Every sum saturates to [-(2^(W-1)-1), +(2^(W-1)-1)], which is [-31, 31] for W=6. No output ever carries the most negative code (-32 for W=6).
- R7: An input equal to the most negative code is treated as having the largest positive magnitude (31 for W=6). Its sign stays negative.
- R8: A group sampled with `in_valid` high at a rising edge appears on the outputs with `out_valid` high exactly `LAT` cycles later. `out_valid` is never high without a matching input group.
- R9: Lanes are independent. Lane k uses bits [k*W +: W] of every data port, and messages are two's complement.
- R10: A synchronous active-high `rst` drops `out_valid` at the next edge and discards all groups in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Input group valid |
| r_hi_i | input | LANES*W | Right message of upper node, layer i |
| r_lo_i | input | LANES*W | Right message of lower (j+N/2) node, layer i |
| l_odd_i | input | LANES*W | Left message of odd node, layer i+1 |
| l_even_i | input | LANES*W | Left message of even node, layer i+1 |
| out_valid | output | 1 | Output group valid |
| l_hi_o | output | LANES*W | Updated left message, upper node, layer i |
| l_lo_o | output | LANES*W | Updated left message, lower node, layer i |
| r_odd_o | output | LANES*W | Updated right message, odd node, layer i+1 |
| r_even_o | output | LANES*W | Updated right message, even node, layer i+1 |

## Verification
The bench builds the unit with LANES=4, W=6 and LAT=3. Four lanes let every lane carry a different corner case in the same group, so any crossing of lane slices shows up at once. LAT=3 keeps one pure delay stage beyond the two arithmetic stages. The 6-bit width reaches every saturation point and the -32 input code with directed vectors as well as with random ones.

// File: rtl/bp_sat_add.sv
module bp_sat_add #(
  parameter int W = 6
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int MAXP = (1 << (W-1)) - 1;
  localparam logic signed [W:0] HI = MAXP;
  localparam logic signed [W:0] LO = -MAXP;

  logic signed [W:0] s;

  always_comb begin
    s = {a[W-1], a} + {b[W-1], b};
    if (s > HI)      y = HI[W-1:0];
    else if (s < LO) y = LO[W-1:0];
    else             y = s[W-1:0];
  end
endmodule

// File: rtl/bp_minsum.sv
module bp_minsum #(
  parameter int W = 6
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] g
);
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-2:0] ma, mb, mm;

  function automatic logic [W-2:0] sat_mag(input logic signed [W-1:0] v);
    logic signed [W-1:0] n;
    n = -v;
    if (v == MINV)   sat_mag = '1;
    else if (v[W-1]) sat_mag = n[W-2:0];
    else             sat_mag = v[W-2:0];
  endfunction

  always_comb begin
    ma = sat_mag(a);
    mb = sat_mag(b);
    mm = (ma < mb) ? ma : mb;
    g  = (a[W-1] ^ b[W-1]) ? -$signed({1'b0, mm}) : $signed({1'b0, mm});
  end

  // magnitude and sign checks against the raw inputs
  logic signed [W:0] ga, aa, ba;
  always_comb begin
    ga = (g < 0) ? -{g[W-1], g} : {g[W-1], g};
    aa = (a < 0) ? -{a[W-1], a} : {a[W-1], a};
    ba = (b < 0) ? -{b[W-1], b} : {b[W-1], b};
    if (!$isunknown({a, b})) begin
      p_gmag_r5: assert (ga <= aa && ga <= ba);
      p_gsign_r5: assert (g == 0 || (g[W-1] == (a[W-1] ^ b[W-1])));
    end
  end
endmodule

// File: rtl/bp_lane.sv
module bp_lane #(
  parameter int W   = 6,
  parameter int LAT = 4
) (
  input  logic                clk,
  input  logic signed [W-1:0] r_hi,
  input  logic signed [W-1:0] r_lo,
  input  logic signed [W-1:0] l_odd,
  input  logic signed [W-1:0] l_even,
  output logic signed [W-1:0] l_hi_q,
  output logic signed [W-1:0] l_lo_q,
  output logic signed [W-1:0] r_odd_q,
  output logic signed [W-1:0] r_even_q
);
  localparam int DEPTH = LAT - 1;
  localparam int PW    = 4 * W;

  // stage 1: shared terms
  logic signed [W-1:0] g_hl, sum_el;
  logic signed [W-1:0] s1_g, s1_sum, s1_rh, s1_rl, s1_lo, s1_le;

  bp_minsum  #(.W(W)) u_g_shared (.a(r_hi),   .b(l_odd), .g(g_hl));
  bp_sat_add #(.W(W)) u_s_shared (.a(l_even), .b(r_lo),  .y(sum_el));

  always_ff @(posedge clk) begin
    s1_g   <= g_hl;
    s1_sum <= sum_el;
    s1_rh  <= r_hi;
    s1_rl  <= r_lo;
    s1_lo  <= l_odd;
    s1_le  <= l_even;
  end

  // stage 2: four outputs
  logic signed [W-1:0] n_lhi, n_llo, n_rodd, n_reven;

  bp_minsum  #(.W(W)) u_lhi   (.a(s1_lo), .b(s1_sum), .g(n_lhi));
  bp_minsum  #(.W(W)) u_rodd  (.a(s1_rh), .b(s1_sum), .g(n_rodd));
  bp_sat_add #(.W(W)) u_llo   (.a(s1_g),  .b(s1_le),  .y(n_llo));
  bp_sat_add #(.W(W)) u_reven (.a(s1_g),  .b(s1_rl),  .y(n_reven));

  logic [PW-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    pipe[0] <= {n_lhi, n_llo, n_rodd, n_reven};
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_delay
    always_ff @(posedge clk) begin
      pipe[k] <= pipe[k-1];
    end
  end

  assign l_hi_q   = pipe[DEPTH-1][4*W-1:3*W];
  assign l_lo_q   = pipe[DEPTH-1][3*W-1:2*W];
  assign r_odd_q  = pipe[DEPTH-1][2*W-1:W];
  assign r_even_q = pipe[DEPTH-1][W-1:0];
endmodule

// File: rtl/polar_bp_pe_array.sv
module polar_bp_pe_array #(
  parameter int LANES = 2,
  parameter int W     = 6,
  parameter int LAT   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [LANES*W-1:0] r_hi_i,
  input  logic [LANES*W-1:0] r_lo_i,
  input  logic [LANES*W-1:0] l_odd_i,
  input  logic [LANES*W-1:0] l_even_i,
  output logic               out_valid,
  output logic [LANES*W-1:0] l_hi_o,
  output logic [LANES*W-1:0] l_lo_o,
  output logic [LANES*W-1:0] r_odd_o,
  output logic [LANES*W-1:0] r_even_o
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam int CW = $clog2(LAT + 1);

  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  assign out_valid = vpipe[LAT-1];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bp_lane #(.W(W), .LAT(LAT)) u_lane (
      .clk      (clk),
      .r_hi     (r_hi_i[k*W +: W]),
      .r_lo     (r_lo_i[k*W +: W]),
      .l_odd    (l_odd_i[k*W +: W]),
      .l_even   (l_even_i[k*W +: W]),
      .l_hi_q   (l_hi_o[k*W +: W]),
      .l_lo_q   (l_lo_o[k*W +: W]),
      .r_odd_q  (r_odd_o[k*W +: W]),
      .r_even_q (r_even_o[k*W +: W])
    );

    p_no_min_code_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (l_hi_o[k*W +: W] != MINV && l_lo_o[k*W +: W] != MINV &&
                     r_odd_o[k*W +: W] != MINV && r_even_o[k*W +: W] != MINV));
  end

  // cycles since reset, saturating at LAT
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                       since_rst <= '0;
    else if (since_rst != CW'(LAT)) since_rst <= since_rst + 1'b1;
  end

  p_no_early_out_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> since_rst == CW'(LAT));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/test_polar_bp_pe_array.sv
module test_polar_bp_pe_array;
  localparam int LANES = 4;
  localparam int W     = 6;
  localparam int LAT   = 3;
  localparam int VW    = LANES * W;
  localparam int MAXP  = (1 << (W-1)) - 1;
  localparam int MINC  = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [VW-1:0] r_hi_i = '0, r_lo_i = '0, l_odd_i = '0, l_even_i = '0;
  logic out_valid;
  logic [VW-1:0] l_hi_o, l_lo_o, r_odd_o, r_even_o;

  polar_bp_pe_array #(.LANES(LANES), .W(W), .LAT(LAT)) i_polar_bp_pe_array (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .r_hi_i(r_hi_i), .r_lo_i(r_lo_i), .l_odd_i(l_odd_i), .l_even_i(l_even_i),
    .out_valid(out_valid),
    .l_hi_o(l_hi_o), .l_lo_o(l_lo_o), .r_odd_o(r_odd_o), .r_even_o(r_even_o)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [VW-1:0] e_lhi, e_llo, e_rodd, e_reven;
    int t;
    string tag;
  } exp_t;
  exp_t q[$];

  function automatic int bsat(int v);
    if (v > MAXP) return MAXP;
    if (v < -MAXP) return -MAXP;
    return v;
  endfunction

  function automatic int bmag(int v);
    if (v == MINC) return MAXP;
    return (v < 0) ? -v : v;
  endfunction

  function automatic int bg(int x, int y);
    int m;
    m = (bmag(x) < bmag(y)) ? bmag(x) : bmag(y);
    return ((x < 0) != (y < 0)) ? -m : m;
  endfunction

  function automatic int fld(logic [VW-1:0] v, int k);
    logic signed [W-1:0] s;
    s = v[k*W +: W];
    return int'(s);
  endfunction

  task automatic check(string req, string tag, int lane, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s (%s) lane %0d got %0d expected %0d", req, tag, lane, got, exp);
    end
  endtask

  task automatic send(logic [VW-1:0] rh, logic [VW-1:0] rl,
                      logic [VW-1:0] lo, logic [VW-1:0] le, string tag);
    exp_t e;
    @(negedge clk);
    r_hi_i = rh; r_lo_i = rl; l_odd_i = lo; l_even_i = le;
    in_valid = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      int a, b, c, d, s, gg;
      a = fld(rh, k); b = fld(rl, k); c = fld(lo, k); d = fld(le, k);
      s  = bsat(d + b);
      gg = bg(a, c);
      e.e_lhi[k*W +: W]   = W'(bg(c, s));
      e.e_llo[k*W +: W]   = W'(bsat(gg + d));
      e.e_rodd[k*W +: W]  = W'(bg(a, s));
      e.e_reven[k*W +: W] = W'(bsat(gg + b));
    end
    e.t = cyc;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [VW-1:0] pack4(int v0, int v1, int v2, int v3);
    logic [VW-1:0] r;
    r = '0;
    r[0 +: W] = W'(v0); r[W +: W] = W'(v1); r[2*W +: W] = W'(v2); r[3*W +: W] = W'(v3);
    return r;
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL R8 out_valid with nothing pending: got 1 expected 0");
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R8", e.tag, 0, cyc - e.t, LAT);
          for (int k = 0; k < LANES; k++) begin
            check("R1", e.tag, k, fld(l_hi_o, k),   fld(e.e_lhi, k));
            check("R2", e.tag, k, fld(l_lo_o, k),   fld(e.e_llo, k));
            check("R3", e.tag, k, fld(r_odd_o, k),  fld(e.e_rodd, k));
            check("R4", e.tag, k, fld(r_even_o, k), fld(e.e_reven, k));
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    for (int i = 0; i < LAT + 2; i++) begin
      @(negedge clk);
      check("R10", "after reset", 0, int'(out_valid), 0);
    end

    // R5 plain min-sum: same and opposite signs, zeros
    send(pack4(5, -7, 0, 9), pack4(1, 2, 3, -4), pack4(3, 4, -6, -9), pack4(2, -1, 5, 0), "R5 signs");
    send(pack4(-10, 10, -1, 0), pack4(0, 0, 0, 0), pack4(-12, -3, 1, 7), pack4(0, 0, 0, 0), "R5 zeros");
    // R6 saturation of sums
    send(pack4(31, -31, 20, -20), pack4(31, -31, 25, -25), pack4(31, -31, 20, -20), pack4(31, -31, 25, -25), "R6 clamp");
    // R7 most negative code on every input
    send(pack4(-32, -32, 31, -32), pack4(-32, 5, -32, 0), pack4(-32, 31, -32, 3), pack4(-32, -32, 1, -32), "R7 min code");
    // R9 lanes carry distinct values
    send(pack4(1, 2, 3, 4), pack4(-5, -6, -7, -8), pack4(9, 10, 11, 12), pack4(-13, 14, -15, 16), "R9 lanes");
    idle(LAT + 2);

    // R8 back-to-back stream with gaps
    for (int i = 0; i < 150; i++) begin
      logic [VW-1:0] v [4];
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < LANES; k++)
          v[j][k*W +: W] = W'($urandom_range(0, (1 << W) - 1));
      send(v[0], v[1], v[2], v[3], "R8 random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(LAT + 2);
    check("R8", "drain", 0, q.size(), 0);

    // R10: reset with groups in flight
    send(pack4(4, 4, 4, 4), pack4(4, 4, 4, 4), pack4(4, 4, 4, 4), pack4(4, 4, 4, 4), "R10 flush");
    send(pack4(6, 6, 6, 6), pack4(6, 6, 6, 6), pack4(6, 6, 6, 6), pack4(6, 6, 6, 6), "R10 flush");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R10", "reset in flight", 0, int'(out_valid), 0);
    q.delete();
    rst = 1'b0;
    for (int i = 0; i < LAT + 1; i++) begin
      @(negedge clk);
      check("R10", "no stale output", 0, int'(out_valid), 0);
    end
    send(pack4(-3, 8, 0, 31), pack4(2, -8, 0, 31), pack4(7, 1, 0, -31), pack4(-2, 2, 0, 31), "R10 resume");
    idle(LAT + 2);
    check("R8", "final drain", 0, q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule